// File: doc/BRIEF.md
# Compact 16-bit Single-Cycle Processor Core

This block is a small processor that completes one fixed-length 16-bit instruction in every clock cycle. Each cycle it fetches the word at the current program counter from an internal instruction array. It reads two operands from an eight-entry register file and forms a result or an address in a combinational ALU. It then writes back to the register file or to an internal data array at the next rising edge. A decoder turns the 4-bit opcode into a small bundle of control strobes. A separate ALU-selection decode picks the arithmetic operation.

Four operations are implemented: word load, word store, register-register add and unconditional jump. Any other opcode only advances the program counter. Both memories are filled through a load port, and only while reset is held. After reset is released the core runs on its own. A debug port shows the current program counter and the register-file and data-memory writes that the current instruction will commit.

Top module: `cpu16_core`

## Requirements
- R1: Opcode 0000 (bits [15:12]) loads a word: register [8:6] receives data memory at the word address formed from register [11:9] plus the offset in [5:0].
- R2: Opcode 0001 stores a word: register [8:6] is written to data memory at the word address formed from register [11:9] plus the offset in [5:0], and no register is written.
- R3: Opcode 0010 adds: register [5:3] receives register [11:9] plus register [8:6], modulo 2^16.
- R4: Opcode 1101 jumps: the next PC keeps bits [15:13] of PC+2, takes the 12-bit field [11:0] in bits [12:1], and has bit 0 cleared.
- R5: Every non-jump instruction advances the byte-addressed PC by 2. Opcodes other than 0000, 0001, 0010 and 1101 write neither registers nor memory.
- R6: Load and store offsets are sign-extended from 6 bits. The low 8 bits of the sum select one of 256 data words, so base 0 with offset -1 addresses word 255.
- R7: A synchronous active-high reset sets the PC and all eight registers to zero and suppresses all writes by the core, while both memories keep their contents.
- R8: When loadEn is high during reset, loadData is written at the next edge to instruction word loadAddr (loadSel=0, the word fetched at byte PC 2*loadAddr) or to data word loadAddr (loadSel=1). When reset is low the load port has no effect.
- R9: In every cycle the debug port shows the current PC and the register write (strobe, index, data) and data-memory write (strobe, word address, data) that take effect at the next rising edge. At most one of the register write, the memory write and a jump is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| loadEn | input | 1 | Memory load strobe, honoured only during reset |
| loadSel | input | 1 | Load target: 0 instruction memory, 1 data memory |
| loadAddr | input | 8 | Word index for the load |
| loadData | input | 16 | Word to load |
| dbgPc | output | 16 | Current program counter (byte address) |
| dbgRegWe | output | 1 | Register write strobe of the current instruction |
| dbgRegAddr | output | 3 | Register index being written |
| dbgRegData | output | 16 | Value being written to the register |
| dbgMemWe | output | 1 | Data memory write strobe of the current instruction |
| dbgMemAddr | output | 8 | Data memory word address being written |
| dbgMemData | output | 16 | Value being written to data memory |

## Verification
The assertions check on every cycle that the PC steps by two except on jumps, and that a jump lands on the composed target. They also check that register and memory writes land where the debug port announced them, that reset returns the PC to zero, that the strobes are mutually exclusive, and that a load request outside reset leaves data memory unchanged. Only the bench's looping program can show that the ISA semantics compose correctly: that a loaded count feeds the adder, that the stored count rises by one each pass, and that a negative offset wraps to word 255. The bench also shows that a second reset clears registers a previous run dirtied while memory keeps the running count.

// File: rtl/cpu16_pkg.sv
package cpu16_pkg;

  localparam int XLEN = 16;
  localparam int NREG = 8;
  localparam int RAW  = $clog2(NREG);

  localparam logic [3:0] OP_LOAD  = 4'b0000;
  localparam logic [3:0] OP_STORE = 4'b0001;
  localparam logic [3:0] OP_ADD   = 4'b0010;
  localparam logic [3:0] OP_JUMP  = 4'b1101;

  typedef enum logic [0:0] {
    ALU_ZERO = 1'b0,
    ALU_ADD  = 1'b1
  } aluOp_e;

  // Strobes from the decoder to the datapath
  typedef struct packed {
    logic   regWe;     // write register file
    logic   memWe;     // write data memory
    logic   memToReg;  // write-back source is data memory
    logic   dstRd;     // destination field [5:3] instead of [8:6]
    logic   useImm;    // ALU B operand is the sign-extended offset
    logic   jump;      // redirect the PC
    aluOp_e aluOp;
  } ctrl_t;

endpackage

// File: rtl/cpu16_ctrl.sv
module cpu16_ctrl
  import cpu16_pkg::*;
(
  input  logic [3:0] opcode,
  output ctrl_t      ctrl
);

  aluOp_e aluSel;

  // ALU selection decode, kept apart from the main decoder
  always_comb begin
    unique case (opcode)
      OP_LOAD, OP_STORE, OP_ADD: aluSel = ALU_ADD;
      default:                   aluSel = ALU_ZERO;
    endcase
  end

  // Main decoder
  always_comb begin
    ctrl       = '0;
    ctrl.aluOp = aluSel;
    unique case (opcode)
      OP_LOAD: begin
        ctrl.regWe    = 1'b1;
        ctrl.memToReg = 1'b1;
        ctrl.useImm   = 1'b1;
      end
      OP_STORE: begin
        ctrl.memWe  = 1'b1;
        ctrl.useImm = 1'b1;
      end
      OP_ADD: begin
        ctrl.regWe = 1'b1;
        ctrl.dstRd = 1'b1;
      end
      OP_JUMP: ctrl.jump = 1'b1;
      default: ;
    endcase
  end

endmodule

// File: rtl/cpu16_regfile.sv
module cpu16_regfile
  import cpu16_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [RAW-1:0]  rdAddrA,
  input  logic [RAW-1:0]  rdAddrB,
  output logic [XLEN-1:0] rdDataA,
  output logic [XLEN-1:0] rdDataB,
  input  logic            wrEn,
  input  logic [RAW-1:0]  wrAddr,
  input  logic [XLEN-1:0] wrData
);

  logic [XLEN-1:0] regs [NREG];

  assign rdDataA = regs[rdAddrA];
  assign rdDataB = regs[rdAddrB];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (wrEn) begin
      regs[wrAddr] <= wrData;
    end
  end

  // R9: an announced register write lands at the next edge
  p_reg_write_r9: assert property (@(posedge clk) disable iff (rst)
    wrEn |=> regs[$past(wrAddr)] == $past(wrData));

  // R7: reset leaves every register at zero
  p_reset_regs_r7: assert property (@(posedge clk)
    rst |=> (regs[rdAddrA] == '0 && regs[rdAddrB] == '0) || !rst);

endmodule

// File: rtl/cpu16_datapath.sv
module cpu16_datapath
  import cpu16_pkg::*;
#(
  parameter int MEM_AW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              loadEn,
  input  logic              loadSel,
  input  logic [MEM_AW-1:0] loadAddr,
  input  logic [XLEN-1:0]   loadData,
  input  ctrl_t             ctrl,
  output logic [3:0]        opcode,
  output logic [XLEN-1:0]   dbgPc,
  output logic              dbgRegWe,
  output logic [RAW-1:0]    dbgRegAddr,
  output logic [XLEN-1:0]   dbgRegData,
  output logic              dbgMemWe,
  output logic [MEM_AW-1:0] dbgMemAddr,
  output logic [XLEN-1:0]   dbgMemData
);

  localparam int MEM_WORDS = 1 << MEM_AW;
  localparam int OFF_W     = 6;
  localparam int JMP_W     = 12;

  logic [XLEN-1:0] imem [MEM_WORDS];
  logic [XLEN-1:0] dmem [MEM_WORDS];

  logic [XLEN-1:0]   pc, pcPlus2, pcNext, jumpTarget, instr;
  logic [RAW-1:0]    rsIdx, rtIdx, rdIdx, wAddr;
  logic [XLEN-1:0]   offSext, opA, opB, aluB, aluY, memRd, wData;
  logic [MEM_AW-1:0] memAddr;
  logic              regWe, memWe;

  // Fetch and field split
  assign instr   = imem[pc[MEM_AW:1]];
  assign opcode  = instr[15:12];
  assign rsIdx   = instr[11:9];
  assign rtIdx   = instr[8:6];
  assign rdIdx   = instr[5:3];
  assign offSext = {{(XLEN-OFF_W){instr[OFF_W-1]}}, instr[OFF_W-1:0]};

  cpu16_regfile u_regs (
    .clk     (clk),
    .rst     (rst),
    .rdAddrA (rsIdx),
    .rdAddrB (rtIdx),
    .rdDataA (opA),
    .rdDataB (opB),
    .wrEn    (regWe),
    .wrAddr  (wAddr),
    .wrData  (wData)
  );

  // Combinational ALU
  assign aluB = ctrl.useImm ? offSext : opB;
  always_comb begin
    unique case (ctrl.aluOp)
      ALU_ADD: aluY = opA + aluB;
      default: aluY = '0;
    endcase
  end

  // Data memory and write-back
  assign memAddr = aluY[MEM_AW-1:0];
  assign memRd   = dmem[memAddr];
  assign wAddr   = ctrl.dstRd ? rdIdx : rtIdx;
  assign wData   = ctrl.memToReg ? memRd : aluY;
  assign regWe   = ctrl.regWe & ~rst;
  assign memWe   = ctrl.memWe & ~rst;

  // Next PC
  assign pcPlus2    = pc + XLEN'(2);
  assign jumpTarget = {pcPlus2[XLEN-1:JMP_W+1], instr[JMP_W-1:0], 1'b0};
  assign pcNext     = ctrl.jump ? jumpTarget : pcPlus2;

  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= pcNext;
  end

  always_ff @(posedge clk) begin
    if (rst && loadEn && !loadSel) imem[loadAddr] <= loadData;
  end

  always_ff @(posedge clk) begin
    if (rst && loadEn && loadSel) dmem[loadAddr] <= loadData;
    else if (memWe)               dmem[memAddr]  <= opB;
  end

  assign dbgPc      = pc;
  assign dbgRegWe   = regWe;
  assign dbgRegAddr = wAddr;
  assign dbgRegData = wData;
  assign dbgMemWe   = memWe;
  assign dbgMemAddr = memAddr;
  assign dbgMemData = opB;

  // R5: straight-line flow steps by one instruction
  p_pc_step_r5: assert property (@(posedge clk) disable iff (rst)
    !ctrl.jump |=> pc == $past(pc) + XLEN'(2));

  // R4: a jump lands on the composed target
  p_jump_target_r4: assert property (@(posedge clk) disable iff (rst)
    ctrl.jump |=> pc == {$past(pcPlus2[XLEN-1:JMP_W+1]), $past(instr[JMP_W-1:0]), 1'b0});

  // R7: reset returns the PC to zero
  p_reset_pc_r7: assert property (@(posedge clk)
    rst |=> pc == '0);

  // R9: write strobes and jump never overlap
  p_strobe_excl_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({regWe, memWe, ctrl.jump}));

  // R2: an announced store lands at the next edge
  p_mem_write_r2: assert property (@(posedge clk) disable iff (rst)
    memWe |=> dmem[$past(memAddr)] == $past(opB));

  // R8: a load request outside reset leaves data memory alone
  p_load_ignored_r8: assert property (@(posedge clk) disable iff (rst)
    (loadEn && loadSel && !(memWe && memAddr == loadAddr))
      |=> dmem[$past(loadAddr)] == $past(dmem[loadAddr]));

endmodule

// File: rtl/cpu16_core.sv
module cpu16_core
  import cpu16_pkg::*;
#(
  parameter int MEM_AW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              loadEn,
  input  logic              loadSel,
  input  logic [MEM_AW-1:0] loadAddr,
  input  logic [15:0]       loadData,
  output logic [15:0]       dbgPc,
  output logic              dbgRegWe,
  output logic [2:0]        dbgRegAddr,
  output logic [15:0]       dbgRegData,
  output logic              dbgMemWe,
  output logic [MEM_AW-1:0] dbgMemAddr,
  output logic [15:0]       dbgMemData
);

  ctrl_t      ctrl;
  logic [3:0] opcode;

  cpu16_ctrl u_ctrl (
    .opcode (opcode),
    .ctrl   (ctrl)
  );

  cpu16_datapath #(.MEM_AW(MEM_AW)) u_dp (
    .clk        (clk),
    .rst        (rst),
    .loadEn     (loadEn),
    .loadSel    (loadSel),
    .loadAddr   (loadAddr),
    .loadData   (loadData),
    .ctrl       (ctrl),
    .opcode     (opcode),
    .dbgPc      (dbgPc),
    .dbgRegWe   (dbgRegWe),
    .dbgRegAddr (dbgRegAddr),
    .dbgRegData (dbgRegData),
    .dbgMemWe   (dbgMemWe),
    .dbgMemAddr (dbgMemAddr),
    .dbgMemData (dbgMemData)
  );

endmodule

// File: tb/test_cpu16_core.sv
`timescale 1ns/1ps
module test_cpu16_core;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        loadEn = 1'b0;
  logic        loadSel = 1'b0;
  logic [7:0]  loadAddr = '0;
  logic [15:0] loadData = '0;
  logic [15:0] dbgPc, dbgRegData, dbgMemData;
  logic        dbgRegWe, dbgMemWe;
  logic [2:0]  dbgRegAddr;
  logic [7:0]  dbgMemAddr;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  localparam logic [15:0] BASE = 16'h0010;

  always #4 clk = ~clk;  // 125 MHz

  cpu16_core i_cpu16_core (
    .clk(clk), .rst(rst), .loadEn(loadEn), .loadSel(loadSel),
    .loadAddr(loadAddr), .loadData(loadData), .dbgPc(dbgPc),
    .dbgRegWe(dbgRegWe), .dbgRegAddr(dbgRegAddr), .dbgRegData(dbgRegData),
    .dbgMemWe(dbgMemWe), .dbgMemAddr(dbgMemAddr), .dbgMemData(dbgMemData)
  );

  // Check the current instruction's debug view, then move to the next cycle
  task automatic step(input logic [15:0] ePc, input logic eRw, input logic [2:0] eRa,
                      input logic [15:0] eRd, input logic eMw, input logic [7:0] eMa,
                      input logic [15:0] eMd, input string tag);
    bit ok;
    #1;
    total++;
    ok = (dbgPc == ePc) && (dbgRegWe == eRw) && (dbgMemWe == eMw);
    if (eRw) ok = ok && (dbgRegAddr == eRa) && (dbgRegData == eRd);
    if (eMw) ok = ok && (dbgMemAddr == eMa) && (dbgMemData == eMd);
    if (!ok) begin
      bad++;
      $display("FAIL %s: got pc=%h rw=%b ra=%0d rd=%h mw=%b ma=%h md=%h, want pc=%h rw=%b ra=%0d rd=%h mw=%b ma=%h md=%h",
               tag, dbgPc, dbgRegWe, dbgRegAddr, dbgRegData, dbgMemWe, dbgMemAddr, dbgMemData,
               ePc, eRw, eRa, eRd, eMw, eMa, eMd);
    end
    @(negedge clk);
  endtask

  task automatic loadWord(input logic sel, input logic [7:0] a, input logic [15:0] d);
    loadEn = 1'b1; loadSel = sel; loadAddr = a; loadData = d;
    @(negedge clk);
    loadEn = 1'b0;
  endtask

  // One pass of the loop body at byte addresses 0x04..0x10
  task automatic loopPass(input logic [15:0] cnt);
    logic [15:0] nxt;
    nxt = cnt + 16'd1;
    step(16'h04, 1, 3'd0, cnt, 0, 8'h00, 16'h0, "R1 load count");
    step(16'h06, 1, 3'd3, nxt, 0, 8'h00, 16'h0, "R3 add");
    step(16'h08, 0, 3'd0, 16'h0, 1, 8'h01, nxt, "R2 store");
    step(16'h0A, 1, 3'd6, nxt, 0, 8'h00, 16'h0, "R1 reload stored");
    step(16'h0C, 0, 3'd0, 16'h0, 1, 8'hFF, nxt, "R6 negative offset");
    step(16'h0E, 0, 3'd0, 16'h0, 0, 8'h00, 16'h0, "R5 unsupported opcode");
    step(16'h10, 0, 3'd0, 16'h0, 0, 8'h00, 16'h0, "R4 jump issue");
  endtask

  task automatic resetCheck(input string tag);
    #1;
    total++;
    if (dbgPc != 16'h0 || dbgRegWe || dbgMemWe) begin
      bad++;
      $display("FAIL %s: got pc=%h rw=%b mw=%b, want pc=0000 rw=0 mw=0",
               tag, dbgPc, dbgRegWe, dbgMemWe);
    end
    @(negedge clk);
  endtask

  initial begin
    @(negedge clk);
    @(negedge clk);
    resetCheck("R7 reset state");
    // Program (word index = byte PC / 2)
    loadWord(0, 8'd0, 16'h2DA8);  // add r5 = r6 + r6
    loadWord(0, 8'd1, 16'h0440);  // load r1 <- [r2+0]
    loadWord(0, 8'd2, 16'h0401);  // load r0 <- [r2+1]   (loop start, byte 4)
    loadWord(0, 8'd3, 16'h2058);  // add r3 = r0 + r1
    loadWord(0, 8'd4, 16'h14C1);  // store [r2+1] <- r3
    loadWord(0, 8'd5, 16'h0581);  // load r6 <- [r2+1]
    loadWord(0, 8'd6, 16'h15BF);  // store [r2-1] <- r6
    loadWord(0, 8'd7, 16'h7FFF);  // unsupported opcode
    loadWord(0, 8'd8, 16'hD002);  // jump to byte 4
    loadWord(1, 8'd0, 16'h0001);
    loadWord(1, 8'd1, BASE);
    loadWord(1, 8'd255, 16'h0000);
    resetCheck("R8 load during reset writes nothing visible");
    rst = 1'b0;

    step(16'h00, 1, 3'd5, 16'h0000, 0, 8'h00, 16'h0, "R3 add of cleared regs");
    step(16'h02, 1, 3'd1, 16'h0001, 0, 8'h00, 16'h0, "R1 load increment");
    for (int i = 0; i < 6; i++) begin
      // R8: load port driven outside reset must change nothing
      if (i == 3) begin loadEn = 1'b1; loadSel = 1'b1; loadAddr = 8'd1; loadData = 16'hAAAA; end
      if (i == 4) begin loadEn = 1'b1; loadSel = 1'b0; loadAddr = 8'd3; loadData = 16'h0000; end
      loopPass(BASE + 16'(i));
      loadEn = 1'b0;
    end

    // Second reset: PC and registers cleared, memories kept
    rst = 1'b1;
    @(negedge clk);
    resetCheck("R7 second reset");
    rst = 1'b0;
    step(16'h00, 1, 3'd5, 16'h0000, 0, 8'h00, 16'h0, "R7 registers cleared");
    step(16'h02, 1, 3'd1, 16'h0001, 0, 8'h00, 16'h0, "R7 memory kept");
    loopPass(BASE + 16'd6);
    loopPass(BASE + 16'd7);
    step(16'h04, 1, 3'd0, BASE + 16'd8, 0, 8'h00, 16'h0, "R4 jump target");

    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: got hung run, want completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule